// File: doc/BRIEF.md
# Prioritized Restart Interrupt Controller

This block is the interrupt unit on the processor side of a small CPU core. It watches five request lines: one nonmaskable line, three maskable restart lines and one general request line. It keeps a global enable bit and three per-source mask bits. When the enable and mask rules admit a request, the block selects the most urgent one and presents it on its output. The output carries the source code and a fixed restart address. For the general line it carries a flag instead, and the vector for that line comes from outside. The selection stays on the output until the core acknowledges it.

Software changes the masks with a set-mask write. Dedicated enable and disable strobes move the global enable. Accepting any request drops the global enable, so a handler runs with further maskable requests held off until it enables them again. A read-mask port shows the mask bits, the enable bit and the pending state of the three restart lines at any time.

The nonmaskable line and the highest restart line are edge-triggered and latched. The two lower restart lines are plain levels: a request that goes away before it is accepted is lost.

Top module: `rstvec_irq_ctrl`

## Requirements
- R1: After reset the output is idle: irq_valid_o=0, irq_src_o=0, irq_vec_o=0. All three mask bits are 1, the global enable is 0 and no request is pending, so mrd_o reads 0x07.
- R2: When several sources qualify in the same cycle, the winner follows this order: nonmaskable (code 1), then restart-high (code 2), then restart-mid (code 3), then restart-low (code 4), then general (code 5). The code appears on irq_src_o one clock after the cycle of acceptance.
- R3: irq_vec_o shows the accepted source's address: 0x24 for the nonmaskable line, 0x3C for restart-high, 0x34 for restart-mid and 0x2C for restart-low. For the general line irq_vec_o is 0 and irq_ext_o is 1. irq_ext_o is 0 in every other case.
- R4: A rising edge on trap_i sets a pending latch. The request is accepted only while that latch is set and trap_i is still high; the global enable and the masks play no part. The latch clears when the request is acknowledged.
- R5: A restart source is accepted only while the global enable is 1 and that source's mask bit is 0.
- R6: The general line has the lowest priority. It needs the global enable and has no mask.
- R7: Accepting any request clears the global enable. en_i sets it and dis_i clears it. If both strobes arrive together, dis_i wins. An acceptance in the same cycle wins over en_i.
- R8: A rising edge on rq75_i sets its pending latch even while that source is masked or disabled. The latch clears on acknowledge of that source, or on a set-mask write with bit 4 set. A new rising edge in the same cycle wins over a clear.
- R9: rq65_i and rq55_i are sampled as levels and are not latched. A request that drops before acceptance is lost.
- R10: A write on mwr_i loads mwdata_i[2:0] into the masks {high, mid, low} only when mwdata_i[3] is 1. When mwdata_i[3] is 0 the masks are left unchanged.
- R11: mrd_o[2:0] shows the masks {high, mid, low}. mrd_o[3] shows the global enable, mrd_o[4] shows rq55_i, mrd_o[5] shows rq65_i and mrd_o[6] shows the restart-high pending latch.
- R12: Once a request is accepted, irq_valid_o, irq_src_o and irq_vec_o hold steady until irq_ack_i arrives, and no other request is accepted meanwhile. An acknowledge given while the output is idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_i | input | 1 | Nonmaskable request, edge and level |
| rq75_i | input | 1 | Restart-high request, edge-latched |
| rq65_i | input | 1 | Restart-mid request, level |
| rq55_i | input | 1 | Restart-low request, level |
| gen_i | input | 1 | General request, level |
| en_i | input | 1 | Set global enable |
| dis_i | input | 1 | Clear global enable |
| mwr_i | input | 1 | Set-mask write strobe |
| mwdata_i | input | 5 | Set-mask data: [2:0] masks, [3] mask-load enable, [4] clear restart-high latch |
| mrd_o | output | 7 | Read-mask view |
| irq_valid_o | output | 1 | Accepted request waiting for acknowledge |
| irq_src_o | output | 3 | Source code of the accepted request |
| irq_vec_o | output | 8 | Fixed restart address |
| irq_ext_o | output | 1 | General request accepted; vector supplied externally |
| irq_ack_i | input | 1 | Acknowledge |

## Verification
The bench targets these corner cases:
- A nonmaskable pulse that falls before it can be taken. A design that accepts on the edge alone would produce a spurious trap.
- A restart-high edge that arrives while masked and disabled. A design that forgets it would never deliver it; a design that does not clear it on acknowledge or on the mask-write reset bit would deliver it twice.
- Stacked requests taken one per enable. A design that keeps the enable set after acceptance, or that orders sources wrongly, produces the wrong sequence of codes and addresses.
- A mask write without its load bit, simultaneous enable and disable strobes, a level request that vanishes before enable, and a stray acknowledge. A design that mishandles any of these shows the wrong read-mask value or an unwanted request.

// File: rtl/rstirq_pkg.sv
package rstirq_pkg;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_TRAP = 3'd1,
        SRC_R75  = 3'd2,
        SRC_R65  = 3'd3,
        SRC_R55  = 3'd4,
        SRC_GEN  = 3'd5
    } src_e;

    localparam int NUM_SRC  = 5;
    localparam int NUM_MASK = 3;

    // mask-write field positions
    localparam int MB_LOW   = 0;
    localparam int MB_MID   = 1;
    localparam int MB_HIGH  = 2;
    localparam int MB_LOAD  = 3;
    localparam int MB_CLR75 = 4;

    typedef struct packed {
        logic                busy;
        src_e                src;
        logic                ie;
        logic [NUM_MASK-1:0] mask;
        logic                p75;
        logic                ptrap;
    } ctl_t;

endpackage

// File: rtl/rstirq_edge.sv
module rstirq_edge #(
    parameter int N = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic prev_d, prev_q;

        always_comb begin
            prev_d = lvl_i[g];
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) prev_q <= 1'b0;
            else         prev_q <= prev_d;
        end

        assign rise_o[g] = lvl_i[g] & ~prev_q;
    end

endmodule

// File: rtl/rstirq_prio.sv
module rstirq_prio
    import rstirq_pkg::*;
#(
    parameter int                 VEC_W    = 8,
    parameter logic [VEC_W-1:0]   VEC_TRAP = 8'h24,
    parameter logic [VEC_W-1:0]   VEC_R75  = 8'h3C,
    parameter logic [VEC_W-1:0]   VEC_R65  = 8'h34,
    parameter logic [VEC_W-1:0]   VEC_R55  = 8'h2C
) (
    input  logic [NUM_SRC-1:0] ok_i,   // bit 0 most urgent
    output logic               any_o,
    output src_e               src_o,
    output logic [VEC_W-1:0]   vec_o
);

    localparam logic [VEC_W-1:0] VTAB [NUM_SRC] =
        '{VEC_TRAP, VEC_R75, VEC_R65, VEC_R55, {VEC_W{1'b0}}};

    always_comb begin
        any_o = |ok_i;
        src_o = SRC_NONE;
        vec_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (ok_i[i]) begin
                src_o = src_e'(3'(i + 1));
                vec_o = VTAB[i];
            end
        end
    end

endmodule

// File: rtl/rstvec_irq_ctrl.sv
module rstvec_irq_ctrl
    import rstirq_pkg::*;
#(
    parameter int               VEC_W    = 8,
    parameter logic [VEC_W-1:0] VEC_TRAP = 8'h24,
    parameter logic [VEC_W-1:0] VEC_R75  = 8'h3C,
    parameter logic [VEC_W-1:0] VEC_R65  = 8'h34,
    parameter logic [VEC_W-1:0] VEC_R55  = 8'h2C
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             trap_i,
    input  logic             rq75_i,
    input  logic             rq65_i,
    input  logic             rq55_i,
    input  logic             gen_i,
    input  logic             en_i,
    input  logic             dis_i,
    input  logic             mwr_i,
    input  logic [4:0]       mwdata_i,
    output logic [6:0]       mrd_o,
    output logic             irq_valid_o,
    output logic [2:0]       irq_src_o,
    output logic [VEC_W-1:0] irq_vec_o,
    output logic             irq_ext_o,
    input  logic             irq_ack_i
);

    localparam int EDGE_N = 2;   // index 0 trap, 1 restart-high

    ctl_t             c_d, c_q;
    logic [VEC_W-1:0] vec_d, vec_q;
    logic [EDGE_N-1:0] rise;
    logic [NUM_SRC-1:0] ok;
    logic             any;
    src_e             sel_src;
    logic [VEC_W-1:0] sel_vec;
    logic             take;

    rstirq_edge #(.N(EDGE_N)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  ({rq75_i, trap_i}),
        .rise_o (rise)
    );

    assign ok[0] = c_q.ptrap & trap_i;
    assign ok[1] = c_q.ie & c_q.p75 & ~c_q.mask[MB_HIGH];
    assign ok[2] = c_q.ie & rq65_i  & ~c_q.mask[MB_MID];
    assign ok[3] = c_q.ie & rq55_i  & ~c_q.mask[MB_LOW];
    assign ok[4] = c_q.ie & gen_i;

    rstirq_prio #(
        .VEC_W    (VEC_W),
        .VEC_TRAP (VEC_TRAP),
        .VEC_R75  (VEC_R75),
        .VEC_R65  (VEC_R65),
        .VEC_R55  (VEC_R55)
    ) u_prio (
        .ok_i  (ok),
        .any_o (any),
        .src_o (sel_src),
        .vec_o (sel_vec)
    );

    always_comb begin
        c_d   = c_q;
        vec_d = vec_q;
        take  = !c_q.busy && any;

        if (c_q.busy && irq_ack_i) begin
            if (c_q.src == SRC_TRAP) c_d.ptrap = 1'b0;
            if (c_q.src == SRC_R75)  c_d.p75   = 1'b0;
            c_d.busy = 1'b0;
            c_d.src  = SRC_NONE;
            vec_d    = '0;
        end

        if (take) begin
            c_d.busy = 1'b1;
            c_d.src  = sel_src;
            vec_d    = sel_vec;
        end

        if (en_i)  c_d.ie = 1'b1;
        if (dis_i) c_d.ie = 1'b0;
        if (take)  c_d.ie = 1'b0;

        if (mwr_i && mwdata_i[MB_LOAD])  c_d.mask = mwdata_i[NUM_MASK-1:0];
        if (mwr_i && mwdata_i[MB_CLR75]) c_d.p75  = 1'b0;

        if (rise[0]) c_d.ptrap = 1'b1;
        if (rise[1]) c_d.p75   = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q.busy  <= 1'b0;
            c_q.src   <= SRC_NONE;
            c_q.ie    <= 1'b0;
            c_q.mask  <= '1;
            c_q.p75   <= 1'b0;
            c_q.ptrap <= 1'b0;
            vec_q     <= '0;
        end else begin
            c_q   <= c_d;
            vec_q <= vec_d;
        end
    end

    assign irq_valid_o = c_q.busy;
    assign irq_src_o   = c_q.src;
    assign irq_vec_o   = vec_q;
    assign irq_ext_o   = c_q.busy && (c_q.src == SRC_GEN);
    assign mrd_o       = {c_q.p75, rq65_i, rq55_i, c_q.ie, c_q.mask};

    // R4
    trap_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!irq_valid_o && c_q.ptrap && trap_i) |=> (irq_valid_o && irq_src_o == SRC_TRAP));

    // R5
    mask_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(irq_valid_o) && irq_src_o inside {SRC_R75, SRC_R65, SRC_R55}) |-> $past(c_q.ie));

    // R7
    ie_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_valid_o) |-> !c_q.ie);

    // R8
    latch75_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise[1] |=> c_q.p75);

    // R12
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_valid_o && !irq_ack_i) |=>
            (irq_valid_o && $stable(irq_src_o) && $stable(irq_vec_o)));

    // R3
    vec_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_valid_o && irq_src_o == SRC_R75) |-> (irq_vec_o == VEC_R75));

endmodule

// File: tb/test_rstvec_irq_ctrl.sv
module test_rstvec_irq_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap = 0, rq75 = 0, rq65 = 0, rq55 = 0, gen = 0;
    logic en = 0, dis = 0, mwr = 0, ack = 0;
    logic [4:0] mwdata = '0;
    logic [6:0] mrd;
    logic       valid, ext;
    logic [2:0] src;
    logic [7:0] vec;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    rstvec_irq_ctrl i_rstvec_irq_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .trap_i(trap), .rq75_i(rq75),
        .rq65_i(rq65), .rq55_i(rq55), .gen_i(gen), .en_i(en), .dis_i(dis),
        .mwr_i(mwr), .mwdata_i(mwdata), .mrd_o(mrd), .irq_valid_o(valid),
        .irq_src_o(src), .irq_vec_o(vec), .irq_ext_o(ext), .irq_ack_i(ack)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit m_busy = 0, m_ie = 0, m_pt = 0, m_p75 = 0, m_pvt = 0, m_pv75 = 0;
    bit [2:0] m_mask = 3'b111;
    int m_src = 0, m_vec = 0;

    always @(posedge clk) begin
        bit rt, r7, tk;
        int ns, nv;
        if (!rst_n) begin
            m_busy = 0; m_ie = 0; m_pt = 0; m_p75 = 0; m_pvt = 0; m_pv75 = 0;
            m_mask = 3'b111; m_src = 0; m_vec = 0;
        end else begin
            rt = trap && !m_pvt;
            r7 = rq75 && !m_pv75;
            ns = 0; nv = 0;
            if (!m_busy) begin
                if (m_pt && trap) begin ns = 1; nv = 'h24; end
                else if (m_ie) begin
                    if (m_p75 && !m_mask[2])     begin ns = 2; nv = 'h3C; end
                    else if (rq65 && !m_mask[1]) begin ns = 3; nv = 'h34; end
                    else if (rq55 && !m_mask[0]) begin ns = 4; nv = 'h2C; end
                    else if (gen)                begin ns = 5; nv = 0;     end
                end
            end
            tk = (ns != 0);
            if (m_busy && ack) begin
                if (m_src == 1) m_pt = 0;
                if (m_src == 2) m_p75 = 0;
                m_busy = 0; m_src = 0; m_vec = 0;
            end
            if (tk) begin m_busy = 1; m_src = ns; m_vec = nv; end
            if (en) m_ie = 1;
            if (dis) m_ie = 0;
            if (tk) m_ie = 0;
            if (mwr && mwdata[3]) m_mask = mwdata[2:0];
            if (mwr && mwdata[4]) m_p75 = 0;
            if (rt) m_pt = 1;
            if (r7) m_p75 = 1;
            m_pvt = trap;
            m_pv75 = rq75;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 valid", valid, m_busy);
            chk("R2 src", src, m_src);
            chk("R3 vec", vec, m_vec);
            chk("R6 ext", ext, (m_busy && m_src == 5));
            chk("R11 mrd", mrd, {m_p75, rq65, rq55, m_ie, m_mask});
        end
    end

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic mask_wr(logic [4:0] d);
        mwr = 1; mwdata = d; tick(); mwr = 0; mwdata = '0;
    endtask

    task automatic pulse_en();  en = 1;  tick(); en = 0;  endtask
    task automatic pulse_dis(); dis = 1; tick(); dis = 0; endtask
    task automatic pulse_ack(); ack = 1; tick(); ack = 0; endtask

    task automatic expect_out(string tag, int v, int s, int ve);
        chk(tag, valid, v);
        chk(tag, src, s);
        chk(tag, vec, ve);
    endtask

    initial begin
        #100000000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick();
        // R1
        expect_out("R1", 0, 0, 0);
        chk("R1 mrd", mrd, 'h07);

        // R4: trap bypasses enable and masks
        trap = 1; tick();
        chk("R4 not yet", valid, 0);
        tick();
        expect_out("R4 trap", 1, 1, 'h24);
        tick();
        expect_out("R12 hold", 1, 1, 'h24);
        pulse_ack(); trap = 0; tick();
        chk("R4 ack clears", valid, 0);

        // R4: short pulse is not accepted until the line is high again
        trap = 1; tick(); trap = 0; tick(2);
        chk("R4 short pulse", valid, 0);
        trap = 1; tick();
        expect_out("R4 late", 1, 1, 'h24);
        pulse_ack(); trap = 0; tick();

        // R10: mask load needs bit 3
        mask_wr(5'b00000);
        chk("R10 no load", mrd, 'h07);
        mask_wr(5'b01000);
        chk("R10 load", mrd, 'h00);

        // R5: mid restart needs enable
        rq65 = 1; tick(2);
        chk("R5 disabled", valid, 0);
        chk("R11 level view", mrd, 'h20);
        pulse_en(); tick();
        expect_out("R5 mid", 1, 3, 'h34);
        chk("R7 ie cleared", mrd[3], 0);
        pulse_ack(); rq65 = 0; tick();

        // R5: masked source ignored
        mask_wr(5'b01010);
        pulse_en();
        rq65 = 1; tick(2);
        chk("R5 masked", valid, 0);
        rq65 = 0;
        mask_wr(5'b01000);

        // R2, R8, R6: stacked requests
        pulse_dis();
        rq75 = 1; tick(2);
        rq65 = 1; rq55 = 1; gen = 1; tick();
        chk("R6 needs enable", valid, 0);
        pulse_en(); tick();
        expect_out("R2 high first", 1, 2, 'h3C);
        chk("R8 pending view", mrd, 'h70);
        pulse_ack(); rq75 = 0;
        chk("R8 ack clears", mrd, 'h30);
        pulse_en(); tick();
        expect_out("R2 mid next", 1, 3, 'h34);
        pulse_ack(); rq65 = 0;
        pulse_en(); tick();
        expect_out("R2 low next", 1, 4, 'h2C);
        pulse_ack(); rq55 = 0;
        pulse_en(); tick();
        expect_out("R6 general", 1, 5, 0);
        chk("R3 ext flag", ext, 1);
        pulse_ack(); gen = 0; tick();

        // R8: latched while masked, cleared by mask write bit 4
        mask_wr(5'b01100);
        rq75 = 1; tick(2);
        chk("R8 masked latch", mrd, 'h44);
        rq75 = 0;
        pulse_en(); tick(2);
        chk("R8 still masked", valid, 0);
        chk("R8 view", mrd, 'h4C);
        mask_wr(5'b10000);
        chk("R8 clear bit", mrd, 'h0C);
        pulse_dis();

        // R9: vanished level request is lost
        rq55 = 1; tick(); rq55 = 0; tick();
        pulse_en(); tick(2);
        chk("R9 level lost", valid, 0);
        pulse_dis();

        // R7: disable wins over enable
        en = 1; dis = 1; tick(); en = 0; dis = 0;
        chk("R7 dis wins", mrd[3], 0);

        // R12: stray acknowledge
        pulse_ack(); tick();
        expect_out("R12 stray ack", 0, 0, 0);

        tick(2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule